// File: doc/BRIEF.md
# Multicycle Datapath Core

This block is the 32-bit datapath of a small multicycle processor. It executes a word-sized subset of instructions: register add, load word, store word, branch-if-equal and jump. One memory holds both the program and its data, and a single ALU does every addition the machine needs. Work is split into steps of one clock each. Between steps, the values are kept in holding registers: instruction, two operand latches, ALU result, memory data and program counter.

A separate controller sequences the steps. It drives the enables and the selects on every cycle. The datapath returns the opcode and function fields of the held instruction, together with a combinational zero flag from the ALU.

The memory has 64 words by default. On reset it is loaded with a fixed boot image. That image holds a short program at word 0 and its operands at words 10 and 11. The program counter and the ALU result register are also brought out as observation outputs.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register and the ALU result register, so `pc_o`, `opcode` and `aluout_o` read zero after reset.
- R2: A fetch cycle loads the instruction register from memory at the program counter and writes PC+4 back into the program counter. In a fetch cycle `ir_we`, `mem_rd` and `pc_we` are high, `iord` is 0, `alu_src_a` is 0 (program counter), `alu_src_b` is 1 (constant 4), `alu_op` is 0 (add) and `pc_src` is 0 (ALU output).
- R3: A decode cycle latches register rs (instruction bits 25:21) into operand A and register rt (bits 20:16) into operand B. In the same cycle it computes the branch target PC + (sign-extended bits 15:0 shifted left by 2), with `alu_src_b` = 3, and stores it in the ALU result register.
- R4: With `alu_src_a` = 1 and `alu_src_b` = 2, the ALU result register receives A + sign-extended bits 15:0, which is the memory address.
- R5: With `iord` = 1 and `mem_rd` high, the memory word at the ALU result register is captured in the memory data register. A later cycle with `reg_we`, `reg_dst` = 0 and `mem_to_reg` = 1 writes that word into register rt.
- R6: With `iord` = 1 and `mem_wr` high, operand B is written to memory at the ALU result register.
- R7: The ALU operation codes are 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than. A result taken with `alu_src_b` = 0 (operand B) is written into register rd (bits 15:11) by a cycle with `reg_we`, `reg_dst` = 1 and `mem_to_reg` = 0.
- R8: With `pc_we_cond` high and `pc_src` = 1, the program counter takes the ALU result register only when the zero flag is high. Otherwise it keeps its value.
- R9: With `pc_we` high and `pc_src` = 2, the program counter becomes its own bits 31:28 concatenated with instruction bits 25:0 and two zero bits.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: The instruction register holds while `ir_we` is low. The program counter holds while both `pc_we` and `pc_we_cond` are low.
- R12: The `zero` output is high exactly when the current ALU result is zero.
- R13: A register read in the same cycle as a write to that register returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional program counter write |
| pc_we_cond | input | 1 | Program counter write qualified by zero |
| iord | input | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_rd | input | 1 | Memory read strobe; read data is zero when low |
| mem_wr | input | 1 | Memory write strobe (writes operand B) |
| ir_we | input | 1 | Instruction register write enable |
| reg_we | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination select: 0 rt, 1 rd |
| mem_to_reg | input | 1 | Write-back select: 0 ALU result register, 1 memory data register |
| alu_src_a | input | 1 | ALU A select: 0 program counter, 1 operand A |
| alu_src_b | input | 2 | ALU B select: 0 operand B, 1 constant 4, 2 sign-extended immediate, 3 immediate shifted by 2 |
| alu_op | input | 3 | ALU operation code |
| pc_src | input | 2 | Next program counter: 0 ALU output, 1 ALU result register, 2 jump target |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |
| pc_o | output | 32 | Program counter |
| aluout_o | output | 32 | ALU result register |

## Verification
The delicate overlap is that a holding register is consumed and rewritten at the same edge. A taken branch loads the program counter from the ALU result register in the very cycle the ALU overwrites that register with the comparison difference. The bench therefore checks that the counter lands on the target computed during decode, not on zero.

The same overlap occurs at load write-back. Operand B is latching the register being written. The bench reads B out through the ALU on the next two cycles and expects first the old value, then the loaded word.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG     = 2'd0,
        SRCB_FOUR    = 2'd1,
        SRCB_IMM     = 2'd2,
        SRCB_IMM_SH2 = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        PCN_ALU  = 2'd0,
        PCN_HELD = 2'd1,
        PCN_JUMP = 2'd2
    } pcsrc_e;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      fn;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    // Reset image: short program at word 0, operands at words 10 and 11.
    function automatic logic [XLEN-1:0] boot_word(input int idx);
        case (idx)
            0:  return 32'h8C02_0028;  // load  r2 <- [r0+40]
            1:  return 32'h8C03_002C;  // load  r3 <- [r0+44]
            2:  return 32'h0043_2020;  // add   r4 <- r2+r3
            3:  return 32'hAC04_0030;  // store [r0+48] <- r4
            4:  return 32'h1042_0002;  // beq   r2,r2,+2
            7:  return 32'h1043_0005;  // beq   r2,r3,+5
            8:  return 32'h0800_000D;  // jump  word 13
            10: return 32'h0000_0007;
            11: return 32'hFFFF_FFF0;
            13: return 32'h0043_0020;  // add   r0 <- r2+r3
            14: return 32'h8C05_0030;  // load  r5 <- [r0+48]
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int W    = 32,
    parameter int AW   = 5,
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/mcd_mem.sv
module mcd_mem
    import mcd_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] addr,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0]    words_q [DEPTH];
    logic [IDXW-1:0] idx;
    logic            unused_addr_bits;

    assign idx              = addr[IDXW+1:2];
    assign unused_addr_bits = ^{addr[W-1:IDXW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= boot_word(i);
        end else if (wr_en) begin
            words_q[idx] <= wdata;
        end
    end

    assign rdata = rd_en ? words_q[idx] : '0;
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcd_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  logic            pc_we_cond,
    input  logic            iord,
    input  logic            mem_rd,
    input  logic            mem_wr,
    input  logic            ir_we,
    input  logic            reg_we,
    input  logic            reg_dst,
    input  logic            mem_to_reg,
    input  logic            alu_src_a,
    input  logic [1:0]      alu_src_b,
    input  logic [2:0]      alu_op,
    input  logic [1:0]      pc_src,
    output logic [5:0]      opcode,
    output logic [5:0]      funct,
    output logic            zero,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] aluout_o
);
    localparam int W = XLEN;

    logic [W-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
    logic [W-1:0] mem_addr, mem_rdata;
    logic [W-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [W-1:0] src_a, src_b, alu_y, imm_ext, pc_next;
    logic [RIDX-1:0] rf_wa;
    logic         pc_load;
    logic         unused_shamt;
    instr_t       fields;

    assign fields       = instr_t'(ir_q);
    assign unused_shamt = ^fields.shamt;
    assign imm_ext      = sext16(ir_q[15:0]);

    // Operand selection for the single shared ALU
    assign src_a = alu_src_a ? a_q : pc_q;
    always_comb begin
        case (srcb_e'(alu_src_b))
            SRCB_REG:     src_b = b_q;
            SRCB_FOUR:    src_b = W'(4);
            SRCB_IMM:     src_b = imm_ext;
            SRCB_IMM_SH2: src_b = imm_ext << 2;
            default:      src_b = b_q;
        endcase
    end

    mcd_alu #(.W(W)) u_alu (
        .a    (src_a),
        .b    (src_b),
        .op   (alu_op_e'(alu_op)),
        .y    (alu_y),
        .zero (zero)
    );

    assign mem_addr = iord ? aluout_q : pc_q;

    mcd_mem #(.W(W), .DEPTH(MEM_WORDS)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .addr  (mem_addr),
        .rd_en (mem_rd),
        .wr_en (mem_wr),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    assign rf_wa = reg_dst ? fields.rd : fields.rt;
    assign rf_wd = mem_to_reg ? mdr_q : aluout_q;

    mcd_regfile #(.W(W), .AW(RIDX)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (fields.rs),
        .ra2 (fields.rt),
        .we  (reg_we),
        .wa  (rf_wa),
        .wd  (rf_wd),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2)
    );

    always_comb begin
        case (pcsrc_e'(pc_src))
            PCN_ALU:  pc_next = alu_y;
            PCN_HELD: pc_next = aluout_q;
            PCN_JUMP: pc_next = {pc_q[W-1:W-4], ir_q[25:0], 2'b00};
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_we | (pc_we_cond & zero);

    // Enabled holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (ir_we)   ir_q <= mem_rdata;
        end
    end

    // Free-running holding registers, one step each
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
            mdr_q    <= mem_rdata;
        end
    end

    assign opcode   = fields.op;
    assign funct    = fields.fn;
    assign pc_o     = pc_q;
    assign aluout_o = aluout_q;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
    input logic        clk,
    input logic        rst,
    input logic        pc_we,
    input logic        pc_we_cond,
    input logic        ir_we,
    input logic [1:0]  pc_src,
    input logic        zero,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic [31:0] aluout,
    input logic [31:0] alu_y,
    input logic [31:0] mdr,
    input logic [31:0] mem_rdata
);
    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> ir == $past(mem_rdata)); // R2

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir)); // R11

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !pc_we_cond) |=> $stable(pc)); // R11

    AST_ALUOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> aluout == $past(alu_y)); // R4

    AST_MDR_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mdr == $past(mem_rdata)); // R5

    AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
        (pc_we_cond && !pc_we && !zero) |=> $stable(pc)); // R8

    AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (rst)
        (pc_we_cond && !pc_we && zero && pc_src == 2'd1) |=> pc == $past(aluout)); // R8

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == 2'd2) |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00}); // R9
endmodule

bind mc_datapath mcd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .ir_we      (ir_we),
    .pc_src     (pc_src),
    .zero       (zero),
    .pc         (pc_q),
    .ir         (ir_q),
    .aluout     (aluout_q),
    .alu_y      (alu_y),
    .mdr        (mdr_q),
    .mem_rdata  (mem_rdata)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;
    localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                           OP_OR = 3'd3, OP_SLT = 3'd4;

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_we, pc_we_cond, iord, mem_rd, mem_wr, ir_we;
    logic        reg_we, reg_dst, mem_to_reg, alu_src_a;
    logic [1:0]  alu_src_b, pc_src;
    logic [2:0]  alu_op;
    logic [5:0]  opcode, funct;
    logic        zero;
    logic [31:0] pc_o, aluout_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mc_datapath dut (
        .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
        .reg_we(reg_we), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .pc_src(pc_src), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_o(pc_o), .aluout_o(aluout_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; pc_we_cond = 0; iord = 0; mem_rd = 0; mem_wr = 0;
        ir_we = 0; reg_we = 0; reg_dst = 0; mem_to_reg = 0;
        alu_src_a = 0; alu_src_b = 2'd0; alu_op = OP_ADD; pc_src = 2'd0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic fetch(input logic [31:0] exp_pc, input logic [5:0] exp_op);
        ir_we = 1; mem_rd = 1; pc_we = 1; alu_src_b = 2'd1;
        tick();
        chk("R2", "pc after fetch", pc_o, exp_pc);
        chk("R2", "opcode after fetch", {26'd0, opcode}, {26'd0, exp_op});
    endtask

    task automatic decode(input logic [31:0] exp_target);
        alu_src_b = 2'd3;
        tick();
        chk("R3", "branch target", aluout_o, exp_target);
    endtask

    task automatic exec_addr(input logic [31:0] exp_addr, input string req);
        alu_src_a = 1; alu_src_b = 2'd2;
        tick();
        chk(req, "effective address", aluout_o, exp_addr);
    endtask

    task automatic mem_read();
        iord = 1; mem_rd = 1; alu_src_a = 1; alu_src_b = 2'd2;
        tick();
    endtask

    task automatic write_back(input logic dst, input logic from_mem);
        reg_we = 1; reg_dst = dst; mem_to_reg = from_mem;
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_ADD;
        tick();
    endtask

    task automatic exec_r(input logic [2:0] op, input logic [31:0] exp, input string what);
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = op;
        tick();
        chk("R7", what, aluout_o, exp);
    endtask

    task automatic t_reset();
        idle();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1", "pc", pc_o, 32'd0);
        chk("R1", "aluout", aluout_o, 32'd0);
        chk("R1", "opcode", {26'd0, opcode}, 32'd0);
    endtask

    task automatic t_loads();
        fetch(32'd4, 6'd35);
        decode(32'd4 + 32'd160);
        exec_addr(32'd40, "R4");
        mem_read();
        write_back(1'b0, 1'b1);
        fetch(32'd8, 6'd35);
        decode(32'd8 + 32'd176);
        exec_addr(32'd44, "R4");
        mem_read();
        write_back(1'b0, 1'b1);
    endtask

    task automatic t_rtype();
        fetch(32'd12, 6'd0);
        chk("R2", "funct", {26'd0, funct}, 32'd32);
        decode(32'd12 + 32'h8080);
        exec_r(OP_ADD, 32'hFFFF_FFF7, "add r2+r3");
        exec_r(OP_SUB, 32'd23, "sub r2-r3");
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_AND;
        #1 chk("R12", "zero on AND result 0", {31'd0, zero}, 32'd1);
        tick();
        chk("R7", "and", aluout_o, 32'd0);
        exec_r(OP_OR, 32'hFFFF_FFF7, "or");
        exec_r(OP_SLT, 32'd0, "slt 7 < -16 signed");
        exec_r(OP_ADD, 32'hFFFF_FFF7, "add again");
        write_back(1'b1, 1'b0);
    endtask

    task automatic t_store();
        fetch(32'd16, 6'd43);
        decode(32'd16 + 32'd192);
        exec_addr(32'd48, "R6");
        iord = 1; mem_wr = 1;
        tick();
    endtask

    task automatic t_branches();
        // taken: ALUOut is overwritten at the same edge PC reads it
        fetch(32'd20, 6'd4);
        decode(32'd28);
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_SUB; pc_we_cond = 1; pc_src = 2'd1;
        #1 chk("R12", "zero on equal operands", {31'd0, zero}, 32'd1);
        tick();
        chk("R8", "taken branch pc", pc_o, 32'd28);
        chk("R8", "aluout holds difference", aluout_o, 32'd0);
        // not taken
        fetch(32'd32, 6'd4);
        decode(32'd52);
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_SUB; pc_we_cond = 1; pc_src = 2'd1;
        #1 chk("R12", "zero on unequal operands", {31'd0, zero}, 32'd0);
        tick();
        chk("R8", "not-taken branch pc", pc_o, 32'd32);
    endtask

    task automatic t_jump_hold();
        fetch(32'd36, 6'd2);
        pc_we = 1; pc_src = 2'd2;
        tick();
        chk("R9", "jump target", pc_o, 32'd52);
        mem_rd = 1; iord = 0;
        tick();
        chk("R11", "pc held", pc_o, 32'd52);
        chk("R11", "opcode held", {26'd0, opcode}, 32'd2);
    endtask

    task automatic t_r0_and_bypass();
        fetch(32'd56, 6'd0);
        decode(32'd56 + 32'h80);
        exec_r(OP_ADD, 32'hFFFF_FFF7, "add into r0");
        write_back(1'b1, 1'b0);
        fetch(32'd60, 6'd35);
        decode(32'd60 + 32'd192);
        exec_addr(32'd48, "R10");
        mem_read();
        write_back(1'b0, 1'b1);
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_ADD;
        tick();
        chk("R13", "B latched old r5 during write", aluout_o, 32'd0);
        alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_ADD;
        tick();
        chk("R5", "loaded word of stored sum (R6)", aluout_o, 32'hFFFF_FFF7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_rtype();
        t_store();
        t_branches();
        t_jump_hold();
        t_r0_and_bypass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule